// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Flush

This block sets the fetch and execute timing for a small core whose program words are 16 bits wide. Each instruction cycle is four clocks long and the block raises one of four phase strobes in each clock. During a cycle it asks for the program word at the current program counter. At the end of the cycle it moves that word into the execute slot and steps the counter. An external decoder looks at the word in the execute slot and reports its class: two-word, conditional, condition met, writes the counter, and a target address. The block samples those flags on the last clock of the cycle.

From those flags the block decides what the next slot carries. A jump or a taken skip discards the word that was already fetched and turns its slot into a forced no-operation. A two-word instruction uses its following slot for its operand word. A word whose top nibble is all ones, when it reaches execution on its own, runs as a no-operation. As a result, a taken skip over a two-word instruction costs three cycles without any extra decoding. Two outputs tell the rest of the core what the current slot holds: one marks a real instruction and the other marks a no-operation slot.

Top module: `instr_cycle_seq`

## Requirements
- R1: `phase_strobe` is one-hot. It shows 4'b0001 in the first clock after reset and moves up one bit per clock. 4'b1000 is followed by 4'b0001, so one instruction cycle is four clocks.
- R2: `fetch_req` is high exactly while `phase_strobe[0]` is high, and the requested address is `pc`. `fetch_word` is sampled on the clock edge that ends the `phase_strobe[3]` clock, which is the end of the cycle. `pc`, `exec_word`, `exec_valid` and `exec_nop` change only at the end of a cycle.
- R3: After reset, the first slot has `pc` = 0, `exec_word` = 0, `exec_valid` = 0 and `exec_nop` = 1.
- R4: With no jump or skip, `pc` rises by one word per cycle, and the word fetched in one cycle becomes `exec_word` in the next cycle.
- R5: A jump is a real single-word slot with `dec_writes_pc` = 1 and either `dec_cond` = 0 or `dec_cond_true` = 1. At the end of that slot, `pc` loads `dec_target` and the next slot is a no-operation. The word at the target executes in the slot after that. A conditional counter write whose condition is false acts as an ordinary instruction.
- R6: A taken skip is a real single-word slot with `dec_cond` = 1, `dec_cond_true` = 1 and `dec_writes_pc` = 0. The next slot is a no-operation, and `pc` still rises by one.
- R7: A real slot with `dec_two_word` = 1 is followed by an operand slot with `exec_valid` = 0 and `exec_nop` = 0. If `dec_writes_pc` is also set, `pc` loads `dec_target` at the end of the first slot. The target word then executes right after the operand slot, so the instruction takes exactly two cycles.
- R8: A word with bits [15:12] = 4'b1111 that enters a slot other than an operand slot becomes a no-operation slot. This is why a taken skip whose skipped instruction has two words takes three cycles.
- R9: The decoder flags have no effect in a slot that is not a real instruction.
- R10: `exec_valid` is high only in slots holding a real instruction. `exec_valid` and `exec_nop` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_word | input | WORD_W | Program word at `pc`, sampled at cycle end |
| dec_two_word | input | 1 | Executing instruction has two words |
| dec_cond | input | 1 | Executing instruction has a conditional test |
| dec_cond_true | input | 1 | The conditional test is met |
| dec_writes_pc | input | 1 | Executing instruction writes the program counter |
| dec_target | input | ADDR_W | New program counter on a jump |
| phase_strobe | output | 4 | One-hot phase within the instruction cycle |
| fetch_req | output | 1 | Program-memory read request |
| pc | output | ADDR_W | Program counter and fetch address |
| exec_word | output | WORD_W | Word in the execute slot |
| exec_valid | output | 1 | Slot carries a real instruction |
| exec_nop | output | 1 | Slot is a flushed or lone-operand no-operation |

## Verification
The checker checks the following on every clock:
- phase rotation and its link to the fetch request;
- that the counter holds steady inside a cycle;
- that jumps and taken skips produce exactly one no-operation slot with the right counter;
- that a two-word instruction produces an operand slot;
- that an all-ones top nibble always yields a no-operation when it is not an operand;
- that flags are ignored outside real slots, and that valid and no-operation are exclusive.

Only the bench scenarios show certain whole sequences. These are the three-cycle cost of a taken skip over a two-word instruction, a two-word jump landing on its target in the cycle after its operand, and an untaken conditional write running as an ordinary instruction. The bench also compares the exact word carried through the slots against a model of program memory.

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq #(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] fetch_word,
  input  logic              dec_two_word,
  input  logic              dec_cond,
  input  logic              dec_cond_true,
  input  logic              dec_writes_pc,
  input  logic [ADDR_W-1:0] dec_target,
  output logic [3:0]        phase_strobe,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] pc,
  output logic [WORD_W-1:0] exec_word,
  output logic              exec_valid,
  output logic              exec_nop
);
  localparam int MARK_W = 4;

  typedef enum logic [1:0] {S_REAL, S_OPER, S_FLUSH, S_ORPH} slot_e;

  logic [1:0]        ph_q;
  slot_e             slot_q, slot_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [WORD_W-1:0] word_q;

  wire cyc_end   = (ph_q == 2'd3);
  wire real_slot = (slot_q == S_REAL);
  wire orphan_in = &fetch_word[WORD_W-1 -: MARK_W];
  wire take_jump = real_slot & dec_writes_pc & (dec_two_word | ~dec_cond | dec_cond_true);
  wire take_skip = real_slot & ~dec_two_word & dec_cond & dec_cond_true & ~dec_writes_pc;

  always_comb begin
    if (real_slot && dec_two_word)  slot_d = S_OPER;
    else if (take_jump || take_skip) slot_d = S_FLUSH;
    else if (orphan_in)             slot_d = S_ORPH;
    else                            slot_d = S_REAL;
  end

  assign pc_d = take_jump ? dec_target : pc_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= 2'd0;
      pc_q   <= '0;
      word_q <= '0;
      slot_q <= S_FLUSH;
    end else begin
      ph_q <= ph_q + 2'd1;
      if (cyc_end) begin
        pc_q   <= pc_d;
        word_q <= fetch_word;
        slot_q <= slot_d;
      end
    end
  end

  assign phase_strobe = 4'b0001 << ph_q;
  assign fetch_req    = (ph_q == 2'd0);
  assign pc           = pc_q;
  assign exec_word    = word_q;
  assign exec_valid   = real_slot;
  assign exec_nop     = (slot_q == S_FLUSH) || (slot_q == S_ORPH);
endmodule

// File: rtl/instr_cycle_seq_chk.sv
module instr_cycle_seq_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        fetch_top,
  input logic              dec_two_word,
  input logic              dec_cond,
  input logic              dec_cond_true,
  input logic              dec_writes_pc,
  input logic [ADDR_W-1:0] dec_target,
  input logic [3:0]        phase_strobe,
  input logic              fetch_req,
  input logic [ADDR_W-1:0] pc,
  input logic              exec_valid,
  input logic              exec_nop
);
  logic [ADDR_W-1:0] pc_inc;
  assign pc_inc = pc + 1'b1;

  wire last_ph = phase_strobe[3];
  wire jump_hit = last_ph && exec_valid && !dec_two_word && dec_writes_pc
                  && (!dec_cond || dec_cond_true);
  wire skip_hit = last_ph && exec_valid && !dec_two_word && dec_cond
                  && dec_cond_true && !dec_writes_pc;

  p_phase_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase_strobe) == 1);
  p_phase_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phase_strobe[3] |=> phase_strobe[0]);
  p_fetch_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req == phase_strobe[0]);
  p_pc_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !last_ph |=> $stable(pc) && $stable(exec_valid) && $stable(exec_nop));
  p_jump_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    jump_hit |=> exec_nop && pc == $past(dec_target));
  p_skip_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    skip_hit |=> exec_nop && pc == $past(pc_inc));
  p_operand_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last_ph && exec_valid && dec_two_word |=> !exec_valid && !exec_nop);
  p_orphan_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_ph && (&fetch_top) && !(exec_valid && dec_two_word) |=> exec_nop);
  p_flags_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    last_ph && !exec_valid |=> pc == $past(pc_inc));
  p_valid_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_valid && exec_nop));
endmodule

bind instr_cycle_seq instr_cycle_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .fetch_top(fetch_word[WORD_W-1 -: 4]),
  .dec_two_word(dec_two_word), .dec_cond(dec_cond), .dec_cond_true(dec_cond_true),
  .dec_writes_pc(dec_writes_pc), .dec_target(dec_target),
  .phase_strobe(phase_strobe), .fetch_req(fetch_req), .pc(pc),
  .exec_valid(exec_valid), .exec_nop(exec_nop)
);

// File: tb/instr_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module instr_cycle_seq_tb_top;
  localparam int AW = 12;
  localparam int WW = 16;
  localparam int K_REAL = 0, K_OPER = 1, K_FLUSH = 2, K_ORPH = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [WW-1:0] fetch_word;
  logic          two_w = 1'b0, cnd = 1'b0, cnd_t = 1'b0, wpc = 1'b0;
  logic [AW-1:0] tgt = '0;
  logic [3:0]    phase_strobe;
  logic          fetch_req;
  logic [AW-1:0] pc;
  logic [WW-1:0] exec_word;
  logic          exec_valid, exec_nop;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_pc;
  logic [WW-1:0] m_word;
  int            m_kind;

  always #4 clk = ~clk;

  instr_cycle_seq #(.ADDR_W(AW), .WORD_W(WW)) dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_word(fetch_word),
    .dec_two_word(two_w), .dec_cond(cnd), .dec_cond_true(cnd_t),
    .dec_writes_pc(wpc), .dec_target(tgt),
    .phase_strobe(phase_strobe), .fetch_req(fetch_req), .pc(pc),
    .exec_word(exec_word), .exec_valid(exec_valid), .exec_nop(exec_nop)
  );

  function automatic logic [WW-1:0] mem_word(input logic [AW-1:0] a);
    if (a[2:0] == 3'd5) mem_word = {4'hF, a};
    else                mem_word = {1'b0, a[2:0], a};
  endfunction

  function automatic int kind_of(input logic [WW-1:0] w);
    kind_of = (w[15:12] == 4'hF) ? K_ORPH : K_REAL;
  endfunction

  assign fetch_word = mem_word(pc);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic t2, input logic c, input logic ct, input logic w,
                      input logic [AW-1:0] tg, input string tag);
    logic [WW-1:0] fw;
    int nk;
    logic [AW-1:0] npc;
    chk({tag, " pc"}, 32'(pc), 32'(m_pc));
    chk({tag, " word"}, 32'(exec_word), 32'(m_word));
    chk({tag, " valid R10"}, 32'(exec_valid), 32'(m_kind == K_REAL));
    chk({tag, " nop R10"}, 32'(exec_nop), 32'(m_kind == K_FLUSH || m_kind == K_ORPH));
    chk("R1 phase0", 32'(phase_strobe), 32'h1);
    chk("R2 fetch_req", 32'(fetch_req), 32'h1);
    two_w = t2; cnd = c; cnd_t = ct; wpc = w; tgt = tg;
    fw = mem_word(m_pc);
    npc = m_pc + 1'b1;
    nk = kind_of(fw);
    if (m_kind == K_REAL) begin
      if (t2) begin
        nk = K_OPER;
        if (w) npc = tg;
      end else if (w && (!c || ct)) begin
        nk = K_FLUSH; npc = tg;
      end else if (c && ct) begin
        nk = K_FLUSH;
      end
    end
    for (int i = 1; i < 4; i++) begin
      @(negedge clk);
      chk("R1 phase", 32'(phase_strobe), 32'(4'b0001 << i));
      chk("R2 pc steady", 32'(pc), 32'(m_pc));
    end
    @(negedge clk);
    m_pc = npc; m_word = fw; m_kind = nk;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_pc = '0; m_word = '0; m_kind = K_FLUSH;
    step(0, 0, 0, 0, '0, "R3");
    step(0, 0, 0, 0, '0, "R4");
    step(0, 0, 0, 1, 12'h100, "R4");
    step(0, 0, 0, 1, 12'h200, "R5");
    step(0, 0, 0, 0, '0, "R9");
    step(0, 0, 0, 0, '0, "R4");
    step(0, 0, 0, 0, '0, "R4");
    step(0, 1, 1, 0, '0, "R4");
    step(0, 0, 0, 0, '0, "R6");
    step(0, 0, 0, 0, '0, "R8");
    step(1, 0, 0, 1, 12'h300, "R8");
    step(0, 0, 0, 0, '0, "R7");
    step(1, 0, 0, 0, '0, "R7");
    step(0, 0, 0, 1, 12'h3FF, "R7");
    step(0, 1, 0, 1, 12'h3FF, "R7");
    step(0, 0, 0, 0, '0, "R5");
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 10) == 0, ($urandom % 5) == 0, $urandom % 2,
           ($urandom % 10) == 0, AW'($urandom), "R4");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule